// File: doc/BRIEF.md
# Passive LCD AC-Bias Toggle Generator

This block drives the AC-bias (modulation) signal of a passive LCD panel. The signal must change polarity at regular intervals so that no DC voltage builds up across the liquid crystal. Software programs a 6-bit rate value through a small write port, and the value can be read back. The block counts the line strobes that an external timing generator produces and inverts its output each time the programmed number of lines has gone by. A rate of zero selects a different source: the output then inverts once on every frame strobe.

A panel-type input marks the attached panel as either an active-matrix (TFT) panel or a passive panel. Modulation is needed only for passive panels. While TFT is selected, the output holds its level and the line count stays at zero. Line and frame strobes are single-cycle pulses in the block's clock domain.

Top module: `lcd_mod_gen`

## Requirements
- R1: After the asynchronous active-low reset, mod_o is 0 and rd_data_o reads 0x00.
- R2: A cycle with wr_en_i high stores wr_data_i[5:0] as the rate from the next cycle on. rd_data_o shows the rate in bits 5:0, and bits 7:6 always read 0 whatever was written to them.
- R3: With a non-zero rate N and passive mode selected, mod_o inverts on every Nth line strobe counted since the last toggle or count clear. The new level appears the cycle after that strobe.
- R4: With a rate of 0 and passive mode selected, mod_o inverts on every frame strobe, and line strobes have no effect on it.
- R5: With a non-zero rate, frame strobes have no effect. A line strobe that coincides with a frame strobe is counted exactly once.
- R6: While tft_sel_i is 1, mod_o holds its level and the line count is cleared. Once passive mode returns, counting restarts from zero.
- R7: A rate write clears the line count, and mod_o does not invert in the write cycle even when a strobe arrives in it. The new rate counts from the first line strobe after the write.
- R8: The extreme rates work. A rate of 1 inverts mod_o on every line strobe, and a rate of 63 needs 63 line strobes per toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Rate register write strobe |
| wr_data_i | input | 8 | Rate register write data |
| rd_data_o | output | 8 | Rate register read data |
| tft_sel_i | input | 1 | 1 = TFT panel, 0 = passive panel |
| line_pulse_i | input | 1 | Single-cycle line strobe |
| frame_pulse_i | input | 1 | Single-cycle frame strobe |
| mod_o | output | 1 | AC-bias modulation output |

## Verification
The bench targets the off-by-one boundary of the line count at rates 1, 3 and 63. A counter that compares against the wrong value would toggle one line early or one line late. It places writes on the same cycle as a line strobe and in the middle of a count, where a design that failed to clear the count or to suppress the toggle would give a short first period or an extra edge. It also asserts line and frame strobes together in both modes: a design with the wrong source selection would toggle twice or count the line twice. Finally it toggles TFT selection mid-count, where a design that held its count would invert early once passive mode returns.

// File: rtl/lcd_mod_pkg.sv
package lcd_mod_pkg;
  localparam int unsigned RATE_W = 6;
  localparam int unsigned REG_W  = 8;
  typedef logic [RATE_W-1:0] rate_t;
endpackage

// File: rtl/mod_rate_reg.sv
module mod_rate_reg
  import lcd_mod_pkg::*;
#(
  parameter int unsigned RW = RATE_W,
  parameter int unsigned DW = REG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [RW-1:0] rate_o,
  output logic [DW-1:0] rd_data_o
);
  localparam int unsigned PAD_W = DW - RW;

  logic [RW-1:0] rate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rate_q <= '0;
    else if (wr_en_i) rate_q <= wr_data_i[RW-1:0];
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_data_o = {{PAD_W{1'b0}}, rate_q};
    end else begin : g_nopad
      assign rd_data_o = rate_q;
    end
  endgenerate

  assign rate_o = rate_q;

  assert_wr_store_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rate_o == $past(wr_data_i[RW-1:0]));
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rate_o));
endmodule

// File: rtl/mod_line_cnt.sv
module mod_line_cnt
  import lcd_mod_pkg::*;
#(
  parameter int unsigned RW = RATE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          line_pulse_i,
  input  logic [RW-1:0] rate_i,
  output logic          hit_o
);
  logic [RW-1:0] cnt_q;
  logic          line_mode;
  logic          last;

  assign line_mode = (rate_i != '0);
  assign last      = (cnt_q == rate_i - RW'(1));
  assign hit_o     = !clr_i && line_mode && line_pulse_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                cnt_q <= '0;
    else if (clr_i || !line_mode)               cnt_q <= '0;
    else if (line_pulse_i) cnt_q <= last ? '0 : cnt_q + RW'(1);
  end

  assert_cnt_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_mode |-> cnt_q < rate_i);
  assert_cnt_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_mode |-> cnt_q == '0);
  assert_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/mod_toggle.sv
module mod_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic frame_mode_i,
  input  logic frame_pulse_i,
  input  logic line_hit_i,
  output logic mod_o
);
  logic mod_q;
  logic flip;

  // source select: frame strobe at rate 0, counted lines otherwise
  assign flip = !hold_i && (frame_mode_i ? frame_pulse_i : line_hit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mod_q <= 1'b0;
    else if (flip) mod_q <= ~mod_q;
  end

  assign mod_o = mod_q;

  assert_flip_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flip |=> mod_o != $past(mod_o));
  assert_still_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flip |=> $stable(mod_o));
endmodule

// File: rtl/lcd_mod_gen.sv
module lcd_mod_gen
  import lcd_mod_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             tft_sel_i,
  input  logic             line_pulse_i,
  input  logic             frame_pulse_i,
  output logic             mod_o
);
  rate_t rate;
  logic  clr;
  logic  hit;

  assign clr = wr_en_i || tft_sel_i;

  mod_rate_reg #(.RW(RATE_W), .DW(REG_W)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rate_o    (rate),
    .rd_data_o (rd_data_o)
  );

  mod_line_cnt #(.RW(RATE_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (clr),
    .line_pulse_i (line_pulse_i),
    .rate_i       (rate),
    .hit_o        (hit)
  );

  mod_toggle u_tgl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .hold_i        (clr),
    .frame_mode_i  (rate == '0),
    .frame_pulse_i (frame_pulse_i),
    .line_hit_i    (hit),
    .mod_o         (mod_o)
  );

  assert_tft_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tft_sel_i |=> $stable(mod_o));
  assert_wr_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> $stable(mod_o));
  assert_frame_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate == '0 && !frame_pulse_i) |=> $stable(mod_o));
  assert_no_line_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate != '0 && !line_pulse_i) |=> $stable(mod_o));
  assert_rd_pad_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[REG_W-1:RATE_W] == '0);
endmodule

// File: tb/sim_lcd_mod_gen.sv
module sim_lcd_mod_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       tft = 1'b0;
  logic       line_p = 1'b0;
  logic       frame_p = 1'b0;
  logic [7:0] rd_data;
  logic       mod;

  int vectors = 0;
  int errors  = 0;
  string tag = "R1";

  int ref_rate = 0;
  int ref_cnt  = 0;
  bit ref_mod  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  lcd_mod_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .tft_sel_i(tft), .line_pulse_i(line_p),
    .frame_pulse_i(frame_p), .mod_o(mod)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_rate <= 0; ref_cnt <= 0; ref_mod <= 1'b0;
    end else if (wr_en) begin
      ref_rate <= wr_data % 64; ref_cnt <= 0;
    end else if (tft) begin
      ref_cnt <= 0;
    end else if (ref_rate == 0) begin
      if (frame_p) ref_mod <= !ref_mod;
    end else if (line_p) begin
      if (ref_cnt + 1 >= ref_rate) begin ref_mod <= !ref_mod; ref_cnt <= 0; end
      else ref_cnt <= ref_cnt + 1;
    end
  end

  always @(negedge clk) begin
    vectors++;
    if (mod !== ref_mod) begin
      errors++;
      $display("FAIL %s: mod_o actual %b expected %b at %0t", tag, mod, ref_mod, $time);
    end
    vectors++;
    if (rd_data !== 8'(ref_rate)) begin
      errors++;
      $display("FAIL %s: rd_data_o actual %h expected %h at %0t", tag, rd_data, 8'(ref_rate), $time);
    end
  end

  task automatic step(input bit l, input bit f, input bit t, input bit w, input logic [7:0] d);
    @(negedge clk);
    line_p = l; frame_p = f; tft = t; wr_en = w; wr_data = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, tft, 0, 8'h00);
  endtask

  task automatic lines(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      step(1, 0, tft, 0, 8'h00);
      idle(gap);
    end
  endtask

  initial begin : watchdog
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    tag = "R4"; // rate 0 after reset: frame strobes toggle, lines ignored
    for (int i = 0; i < 6; i++) begin step(0, 1, 0, 0, 8'h00); lines(2, 1); end
    step(1, 1, 0, 0, 8'h00); idle(2);
    tag = "R2";
    step(0, 0, 0, 1, 8'hFF); idle(2);
    step(0, 0, 0, 1, 8'hC3); idle(2);
    tag = "R3";
    lines(10, 2);
    lines(7, 0);
    tag = "R5";
    for (int i = 0; i < 8; i++) begin step(1, 1, 0, 0, 8'h00); step(0, 1, 0, 0, 8'h00); end
    idle(2);
    tag = "R8";
    step(0, 0, 0, 1, 8'h01); idle(1);
    lines(9, 0); lines(4, 3);
    step(0, 0, 0, 1, 8'h3F); idle(1);
    lines(130, 0);
    tag = "R6";
    step(0, 0, 0, 1, 8'h05); idle(1);
    lines(3, 1);
    step(0, 0, 1, 0, 8'h00); lines(6, 1);
    step(0, 1, 1, 0, 8'h00);
    step(0, 0, 0, 0, 8'h00); lines(12, 1);
    step(0, 0, 0, 1, 8'h00); idle(1);
    step(0, 0, 1, 0, 8'h00); step(0, 1, 1, 0, 8'h00); step(0, 0, 0, 0, 8'h00);
    step(0, 1, 0, 0, 8'h00); idle(2);
    tag = "R7";
    step(0, 0, 0, 1, 8'h04); idle(1);
    lines(3, 1);
    step(1, 0, 0, 1, 8'h02); idle(1);   // line in write cycle not counted
    lines(5, 1);
    step(0, 0, 0, 1, 8'h00); idle(1);
    step(0, 1, 0, 1, 8'h00); idle(1);   // frame in write cycle: no toggle
    step(0, 1, 0, 0, 8'h00); idle(1);
    step(0, 0, 0, 1, 8'h03); idle(1);
    tag = "R3";
    for (int i = 0; i < 400; i++)
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
           $urandom_range(0, 15) == 0, $urandom_range(0, 40) == 0,
           8'($urandom_range(0, 255) % 8));
    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule